// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the feedback divider of a PLL. It divides a fast input clock by a programmable total ratio of N·P + A. Inside it are three parts: a dual-modulus prescaler that divides by P or P+1, a swallow counter, and a program counter. Both counters advance once per prescaler cycle. A set/reset latch drives the modulus-control level `mod_ctl`.

Each division cycle begins with the prescaler at the wide modulus P+1. Once the swallow counter has seen A prescaler cycles, the latch sets. The prescaler then drops to P and the swallow counter freezes. When the program counter has seen N prescaler cycles, the latch clears, a one-clock feedback pulse is issued, and the configuration is reloaded.

The configuration pins are plain control inputs and are sampled only at the cycle boundary. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pswallow_div`

## Requirements
- R1: For a legal configuration (P ≥ 2, A ≤ P, A < N), `fb_pulse` rises once every N·P + A input clocks.
- R2: `fb_pulse` is high for exactly one input clock per division cycle.
- R3: Every division cycle starts with `mod_ctl` = 0, which selects the P+1 modulus. `mod_ctl` is low in the clock where `fb_pulse` is high.
- R4: The encoding is `mod_ctl` = 0 for P+1 and 1 for P. Per division cycle, `mod_ctl` is low for A·(P+1)+1 input clocks and high for the rest. After it rises, the swallow counter holds until the cycle ends.
- R5: With A = 0, the latch sets one clock after the cycle starts, `mod_ctl` is low for exactly one clock, and the ratio is N·P.
- R6: `cfg_p`, `cfg_n` and `cfg_a` are loaded only at the clock edge that ends a division cycle. A change in mid-cycle leaves the current period unchanged, and the next period uses the new values.
- R7: While `rst` is high, `fb_pulse` = 0 and `mod_ctl` = 0, and the configuration is loaded. The first pulse comes N·P + A clocks after the first edge with `rst` low.
- R8: The edge configurations N = 1, A = N−1, A = P and P = 2 follow the same ratio rule as R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_p | input | P_W | Prescaler base modulus P |
| cfg_n | input | N_W | Program count N |
| cfg_a | input | A_W | Swallow count A |
| fb_pulse | output | 1 | One-clock feedback pulse per division cycle |
| mod_ctl | output | 1 | Modulus control: 0 selects P+1, 1 selects P |

## Verification
The bench builds the block with its default widths: 5-bit P, 8-bit N and 5-bit A. These widths reach every corner the requirements name: the two-clock minimum ratio (N = 1, P = 2), A equal to P, A equal to N−1, and P at its 31 maximum. Random sets keep P to 2–17 and N to 1–20, which keeps each period short. That allows many configurations to be measured, each over several periods, together with a mid-cycle reconfiguration.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  // Modulus select level carried by the set/reset latch
  typedef enum logic {
    MOD_WIDE   = 1'b0,  // prescaler divides by P+1
    MOD_NARROW = 1'b1   // prescaler divides by P
  } modsel_e;
endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
  parameter int P_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] ratio_p,
  input  logic           narrow,
  output logic           tick
);
  logic [P_W-1:0] cnt;
  logic [P_W-1:0] terminal;

  // Last count of the current prescaler cycle: P-1 when narrow, P when wide
  assign terminal = narrow ? ratio_p - 1'b1 : ratio_p;
  assign tick     = (cnt == terminal);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: the count never runs past the wide terminal value
  p_pre_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= ratio_p);
  // R1: every prescaler cycle restarts from zero
  p_pre_restart_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));
endmodule

// File: rtl/pswallow_swallow.sv
module pswallow_swallow #(
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           narrow,
  input  logic           clear,
  input  logic [A_W-1:0] limit,
  output logic           hit
);
  logic [A_W-1:0] cnt;

  assign hit = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (tick && !narrow) cnt <= cnt + 1'b1;
  end

  // R4: frozen once the latch has switched to the narrow modulus
  p_sw_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (narrow && !clear) |=> $stable(cnt));
  // R4: never counts past the programmed swallow value
  p_sw_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= limit);
endmodule

// File: rtl/pswallow_program.sv
module pswallow_program #(
  parameter int N_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [N_W-1:0] ratio_n,
  output logic           done
);
  logic [N_W-1:0] cnt;

  assign done = tick && (cnt == ratio_n - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (done) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R1: count stays below N within a division cycle
  p_pg_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio_n);
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int P_W = 5,
  parameter int N_W = 8,
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] cfg_p,
  input  logic [N_W-1:0] cfg_n,
  input  logic [A_W-1:0] cfg_a,
  output logic           fb_pulse,
  output logic           mod_ctl
);
  logic [P_W-1:0] cur_p;
  logic [N_W-1:0] cur_n;
  logic [A_W-1:0] cur_a;
  modsel_e        mod_q;
  logic           fb_q;
  logic           pre_tick;
  logic           sw_hit;
  logic           cyc_end;
  logic           narrow;

  assign narrow = (mod_q == MOD_NARROW);

  pswallow_prescaler #(.P_W(P_W)) u_pre (
    .clk(clk), .rst(rst), .ratio_p(cur_p), .narrow(narrow), .tick(pre_tick)
  );

  pswallow_swallow #(.A_W(A_W)) u_sw (
    .clk(clk), .rst(rst), .tick(pre_tick), .narrow(narrow),
    .clear(cyc_end), .limit(cur_a), .hit(sw_hit)
  );

  pswallow_program #(.N_W(N_W)) u_pg (
    .clk(clk), .rst(rst), .tick(pre_tick), .ratio_n(cur_n), .done(cyc_end)
  );

  // Configuration shadow and modulus latch (reset side has priority)
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_p <= cfg_p;
      cur_n <= cfg_n;
      cur_a <= cfg_a;
      mod_q <= MOD_WIDE;
      fb_q  <= 1'b0;
    end else begin
      fb_q <= cyc_end;
      if (cyc_end) begin
        cur_p <= cfg_p;
        cur_n <= cfg_n;
        cur_a <= cfg_a;
        mod_q <= MOD_WIDE;
      end else if (sw_hit && !narrow) begin
        mod_q <= MOD_NARROW;
      end
    end
  end

  assign fb_pulse = fb_q;
  assign mod_ctl  = mod_q;

  // R1: the loaded configuration must be legal
  p_cfg_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (int'(cur_a) < int'(cur_n)) && (int'(cur_a) <= int'(cur_p)) && (int'(cur_p) >= 2));
  // R2: feedback pulse lasts one clock
  p_one_wide_r2: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse);
  // R3: a new cycle opens on the wide modulus
  p_start_wide_r3: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |-> !mod_ctl);
  // R4: modulus control drops only at the end of a division cycle
  p_fall_at_end_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(mod_ctl) |-> $past(cyc_end));
  // R6: shadow configuration holds between cycle boundaries
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cyc_end)) |-> ($stable(cur_p) && $stable(cur_n) && $stable(cur_a)));
endmodule

// File: tb/pswallow_div_test.sv
`timescale 1ns/1ps
module pswallow_div_test;
  localparam int P_W = 5;
  localparam int N_W = 8;
  localparam int A_W = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic           rst;
  logic [P_W-1:0] cfg_p;
  logic [N_W-1:0] cfg_n;
  logic [A_W-1:0] cfg_a;
  logic           fb_pulse;
  logic           mod_ctl;

  pswallow_div #(.P_W(P_W), .N_W(N_W), .A_W(A_W)) uut (
    .clk(clk), .rst(rst), .cfg_p(cfg_p), .cfg_n(cfg_n), .cfg_a(cfg_a),
    .fb_pulse(fb_pulse), .mod_ctl(mod_ctl)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int per_acc = 0, low_acc = 0, last_per = 0, last_low = 0, pulses = 0;

  // Period monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      per_acc = 0;
      low_acc = 0;
    end else begin
      per_acc++;
      if (fb_pulse === 1'b1) begin
        last_per = per_acc;
        last_low = low_acc;
        per_acc  = 0;
        low_acc  = 0;
        pulses++;
      end
      if (mod_ctl === 1'b0) low_acc++;
    end
  end

  function automatic int ratio(int p, int n, int a);
    return n * p + a;
  endfunction

  function automatic int low_clocks(int p, int a);
    return a * (p + 1) + 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_pulse();
    int target;
    target = pulses;
    step();
    while (pulses == target) step();
  endtask

  task automatic set_cfg(int p, int n, int a);
    cfg_p = P_W'(p);
    cfg_n = N_W'(n);
    cfg_a = A_W'(a);
  endtask

  // Load a configuration, then check k full periods made with it
  task automatic measure(int p, int n, int a, int k, string tag);
    set_cfg(p, n, a);
    wait_pulse();  // reload happens at this boundary
    for (int i = 0; i < k; i++) begin
      wait_pulse();
      chk(last_per == ratio(p, n, a), {tag, " period"}, last_per, ratio(p, n, a));
      chk(last_low == low_clocks(p, a), "R4 low clocks", last_low, low_clocks(p, a));
      chk(mod_ctl == 1'b0, "R3 wide at start", int'(mod_ctl), 0);
      step();
      chk(fb_pulse == 1'b0, "R2 pulse width", int'(fb_pulse), 0);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd24681);
    rst = 1'b1;
    set_cfg(5, 7, 3);
    repeat (3) step();
    // R7: reset state
    chk(fb_pulse == 1'b0, "R7 reset fb", int'(fb_pulse), 0);
    chk(mod_ctl == 1'b0, "R7 reset mod", int'(mod_ctl), 0);
    rst = 1'b0;
    wait_pulse();
    chk(last_per == ratio(5, 7, 3), "R7 first period", last_per, ratio(5, 7, 3));
    wait_pulse();
    chk(last_per == ratio(5, 7, 3), "R1 steady period", last_per, ratio(5, 7, 3));

    // R5: no swallow
    measure(4, 6, 0, 2, "R5 A=0");
    // R8: edge configurations
    measure(2, 1, 0, 3, "R8 N=1 P=2");
    measure(3, 9, 3, 2, "R8 A=P");
    measure(10, 4, 3, 2, "R8 A=N-1");
    measure(31, 3, 2, 2, "R8 P max");
    measure(2, 5, 2, 2, "R8 P=2 A=P");

    // R6: mid-cycle change is held off until the boundary
    measure(6, 8, 2, 1, "R1 pre-change");
    repeat (20) step();
    set_cfg(3, 5, 1);
    wait_pulse();
    chk(last_per == ratio(6, 8, 2), "R6 current period kept", last_per, ratio(6, 8, 2));
    wait_pulse();
    chk(last_per == ratio(3, 5, 1), "R6 new period", last_per, ratio(3, 5, 1));

    // R1: constrained random legal sets
    for (int i = 0; i < 30; i++) begin
      int p, n, a, amax;
      p    = $urandom_range(17, 2);
      n    = $urandom_range(20, 1);
      amax = (p < n - 1) ? p : n - 1;
      a    = $urandom_range(amax, 0);
      measure(p, n, a, 2, "R1 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule